// File: doc/BRIEF.md
# Bridge Fault Protection Supervisor

This block sits between the per-bridge enable requests of a dual full-bridge motor driver and the gate logic, and decides, every clock, whether each bridge may conduct. It watches three kinds of fault. An overcurrent flag on one bridge starts a short detection delay and then removes that bridge's enable for a fixed disable window. When the window ends the bridge retries on its own. A die temperature code and a supply voltage code each pass through a hysteresis comparator. Either of them, when it is active, turns off every bridge and cancels any overcurrent window in progress.

Each fault source also sets a sticky status bit when it newly occurs. The bits stay set until a clear strobe, so firmware can find out what tripped after the event has passed. All thresholds and window lengths are parameters. The bridge count is a parameter, and the timers are replicated per bridge.

Top module: `brg_fault_sup`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the state is: undervoltage lockout active, thermal shutdown inactive, no bridge in its disable window, every enable low, and every sticky bit 0.
- R2: With no fault active and no disable window running, each `br_en` bit equals its `en_req` bit in the same cycle. `br_en` is never high while its request is low.
- R3: An overcurrent flag sampled high on a bridge whose timer is idle starts a delay of DLY_CYC cycles, during which the bridge stays enabled. The bridge is then held off (`oc_off` high) for exactly DIS_CYC cycles and afterwards follows its request again.
- R4: An overcurrent on one bridge has no effect on the enable or timer of any other bridge.
- R5: If the overcurrent flag is still high on the last cycle of the disable window, the delay and disable sequence starts again at once: the bridge is on for DLY_CYC cycles and then off again.
- R6: Thermal shutdown engages on the clock after `temp_code` >= TEMP_HOT. Once engaged, it releases only on the clock after `temp_code` <= TEMP_HOT - TEMP_HYST.
- R7: Undervoltage lockout engages on the clock after `vsup_code` < VSUP_OFF. Once engaged, it releases only on the clock after `vsup_code` >= VSUP_ON.
- R8: While thermal shutdown or undervoltage lockout is active, every `br_en` bit is low. Every overcurrent timer returns to idle on the next clock, and overcurrent flags are not acted on during that time.
- R9: `flt_sticky` bit i (for i below NB) is set when bridge i detects an overcurrent, including on a retry. Bit NB is set on entry into thermal shutdown and bit NB+1 on entry into undervoltage lockout. A `clr_stb` clears all bits on the next clock. A set arriving in the same cycle as the strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | NB | Per-bridge enable request from the controller |
| oc_flag | input | NB | Per-bridge overcurrent detected flag |
| temp_code | input | TEMP_W | Unsigned die temperature code |
| vsup_code | input | VSUP_W | Unsigned supply voltage code |
| clr_stb | input | 1 | One-cycle strobe clearing the sticky status |
| br_en | output | NB | Effective per-bridge enable toward the gate logic |
| oc_off | output | NB | Bridge currently held off by its overcurrent window |
| ot_act | output | 1 | Thermal shutdown active |
| uv_act | output | 1 | Undervoltage lockout active |
| flt_sticky | output | NB+2 | Sticky fault record: overcurrent per bridge, then thermal, then undervoltage |

## Verification
The hardest situations to reach from the ports depend on exact timing. One is an overcurrent flag that is still high on the very last cycle of a disable window. Another is a thermal or supply fault that arrives while a window is counting. Random flags almost never line up with either. The bench therefore holds a flag high across whole windows and raises the temperature in the middle of an open window, then follows with a long biased random run checked against a cycle model. That run keeps the temperature and supply codes near their thresholds.

// File: rtl/brg_fault_pkg.sv
package brg_fault_pkg;

  typedef enum logic [1:0] {
    OC_IDLE  = 2'd0,
    OC_DELAY = 2'd1,
    OC_OFF   = 2'd2
  } oc_phase_e;

  // next value of a hysteresis state bit
  function automatic logic hyst_step(input logic cur, input logic enter_c,
                                     input logic leave_c);
    return cur ? ~leave_c : enter_c;
  endfunction

  // next value of a sticky record bit: set wins over clear
  function automatic logic sticky_step(input logic cur, input logic clr,
                                       input logic set_c);
    return (cur & ~clr) | set_c;
  endfunction

endpackage

// File: rtl/brg_hyst.sv
module brg_hyst #(
  parameter int         W          = 8,
  parameter bit         HIGH_FAULT = 1'b1,
  parameter logic [W-1:0] ENTER_THR = '0,
  parameter logic [W-1:0] LEAVE_THR = '0,
  parameter bit         RST_VAL    = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  output logic         active,
  output logic         enter_evt
);
  import brg_fault_pkg::*;

  logic enter_c;
  logic leave_c;

  generate
    if (HIGH_FAULT) begin : g_high
      assign enter_c = (code >= ENTER_THR);
      assign leave_c = (code <= LEAVE_THR);
    end else begin : g_low
      assign enter_c = (code < ENTER_THR);
      assign leave_c = (code >= LEAVE_THR);
    end
  endgenerate

  assign enter_evt = ~active & enter_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= RST_VAL;
    else        active <= hyst_step(active, enter_c, leave_c);
  end
endmodule

// File: rtl/brg_oc_timer.sv
module brg_oc_timer #(
  parameter int DLY_CYC = 4,
  parameter int DIS_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic hold_off,
  output logic off,
  output logic detect
);
  import brg_fault_pkg::*;

  localparam int CMAX = (DLY_CYC > DIS_CYC) ? DLY_CYC : DIS_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DLY_LD = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] DIS_LD = CW'(DIS_CYC - 1);

  oc_phase_e     ph, ph_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          cnt_done;

  assign cnt_done = (cnt == '0);
  assign off      = (ph == OC_OFF);
  assign detect   = ~hold_off & oc_flag &
                    ((ph == OC_IDLE) | ((ph == OC_OFF) & cnt_done));

  always_comb begin
    ph_nxt  = ph;
    cnt_nxt = cnt;
    if (hold_off) begin
      ph_nxt  = OC_IDLE;
      cnt_nxt = '0;
    end else begin
      unique case (ph)
        OC_IDLE: if (oc_flag) begin
          ph_nxt  = OC_DELAY;
          cnt_nxt = DLY_LD;
        end
        OC_DELAY: if (cnt_done) begin
          ph_nxt  = OC_OFF;
          cnt_nxt = DIS_LD;
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
        OC_OFF: if (cnt_done) begin
          if (oc_flag) begin
            ph_nxt  = OC_DELAY;
            cnt_nxt = DLY_LD;
          end else begin
            ph_nxt  = OC_IDLE;
          end
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
        default: begin
          ph_nxt  = OC_IDLE;
          cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= OC_IDLE;
      cnt <= '0;
    end else begin
      ph  <= ph_nxt;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/brg_fault_log.sv
module brg_fault_log #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] q
);
  import brg_fault_pkg::*;

  generate
    for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[b] <= 1'b0;
        else        q[b] <= sticky_step(q[b], clr, set_vec[b]);
      end
    end
  endgenerate
endmodule

// File: rtl/brg_fault_sup.sv
module brg_fault_sup #(
  parameter int NB        = 2,
  parameter int TEMP_W    = 8,
  parameter int VSUP_W    = 8,
  parameter int TEMP_HOT  = 165,
  parameter int TEMP_HYST = 15,
  parameter int VSUP_ON   = 70,
  parameter int VSUP_OFF  = 60,
  parameter int DLY_CYC   = 4,
  parameter int DIS_CYC   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     en_req,
  input  logic [NB-1:0]     oc_flag,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [VSUP_W-1:0] vsup_code,
  input  logic              clr_stb,
  output logic [NB-1:0]     br_en,
  output logic [NB-1:0]     oc_off,
  output logic              ot_act,
  output logic              uv_act,
  output logic [NB+1:0]     flt_sticky
);
  localparam int SW         = NB + 2;
  localparam int TEMP_LEAVE = TEMP_HOT - TEMP_HYST;

  logic          glob_flt;
  logic          ot_enter;
  logic          uv_enter;
  logic [NB-1:0] oc_detect;
  logic [SW-1:0] set_evt;

  brg_hyst #(
    .W(TEMP_W), .HIGH_FAULT(1'b1),
    .ENTER_THR(TEMP_W'(TEMP_HOT)), .LEAVE_THR(TEMP_W'(TEMP_LEAVE)),
    .RST_VAL(1'b0)
  ) u_ot (
    .clk(clk), .rst_n(rst_n), .code(temp_code),
    .active(ot_act), .enter_evt(ot_enter)
  );

  brg_hyst #(
    .W(VSUP_W), .HIGH_FAULT(1'b0),
    .ENTER_THR(VSUP_W'(VSUP_OFF)), .LEAVE_THR(VSUP_W'(VSUP_ON)),
    .RST_VAL(1'b1)
  ) u_uv (
    .clk(clk), .rst_n(rst_n), .code(vsup_code),
    .active(uv_act), .enter_evt(uv_enter)
  );

  assign glob_flt = ot_act | uv_act;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_br
      brg_oc_timer #(.DLY_CYC(DLY_CYC), .DIS_CYC(DIS_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag[i]),
        .hold_off(glob_flt), .off(oc_off[i]), .detect(oc_detect[i])
      );
    end
  endgenerate

  assign br_en   = en_req & ~oc_off & {NB{~glob_flt}};
  assign set_evt = {uv_enter, ot_enter, oc_detect};

  brg_fault_log #(.N(SW)) u_log (
    .clk(clk), .rst_n(rst_n), .set_vec(set_evt), .clr(clr_stb), .q(flt_sticky)
  );
endmodule

// File: rtl/brg_fault_sup_chk.sv
module brg_fault_sup_chk #(
  parameter int NB        = 2,
  parameter int TEMP_W    = 8,
  parameter int VSUP_W    = 8,
  parameter int TEMP_HOT  = 165,
  parameter int TEMP_HYST = 15,
  parameter int VSUP_ON   = 70,
  parameter int VSUP_OFF  = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NB-1:0]     en_req,
  input logic [TEMP_W-1:0] temp_code,
  input logic [VSUP_W-1:0] vsup_code,
  input logic              clr_stb,
  input logic [NB-1:0]     br_en,
  input logic [NB-1:0]     oc_off,
  input logic              ot_act,
  input logic              uv_act,
  input logic [NB+1:0]     flt_sticky,
  input logic [NB-1:0]     oc_detect,
  input logic [NB+1:0]     set_evt
);
  localparam int TEMP_LEAVE = TEMP_HOT - TEMP_HYST;

  AST_OT_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp_code) >= TEMP_HOT) |=> ot_act); // R6
  AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_act && int'(temp_code) > TEMP_LEAVE) |=> ot_act); // R6
  AST_UV_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(vsup_code) < VSUP_OFF) |=> uv_act); // R7
  AST_UV_STAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_act && int'(vsup_code) >= VSUP_OFF) |=> !uv_act); // R7
  AST_FAULT_BLOCKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_act || uv_act) |-> (br_en == '0)); // R8
  AST_FAULT_CANCELS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_act || uv_act) |=> (oc_off == '0)); // R8
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && set_evt == '0) |=> (flt_sticky == '0)); // R9
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ((flt_sticky & $past(flt_sticky)) == $past(flt_sticky))); // R9

  generate
    for (genvar i = 0; i < NB; i++) begin : g_br
      AST_EN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        br_en[i] |-> en_req[i]); // R2
      AST_OFF_GATES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        oc_off[i] |-> !br_en[i]); // R3
      AST_DETECT_DELAYS: assert property (@(posedge clk) disable iff (!rst_n)
        oc_detect[i] |=> !oc_off[i]); // R3
    end
  endgenerate
endmodule

bind brg_fault_sup brg_fault_sup_chk #(
  .NB(NB), .TEMP_W(TEMP_W), .VSUP_W(VSUP_W), .TEMP_HOT(TEMP_HOT),
  .TEMP_HYST(TEMP_HYST), .VSUP_ON(VSUP_ON), .VSUP_OFF(VSUP_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_req(en_req), .temp_code(temp_code),
  .vsup_code(vsup_code), .clr_stb(clr_stb), .br_en(br_en), .oc_off(oc_off),
  .ot_act(ot_act), .uv_act(uv_act), .flt_sticky(flt_sticky),
  .oc_detect(oc_detect), .set_evt(set_evt)
);

// File: tb/sim_brg_fault_sup.sv
module sim_brg_fault_sup;
  localparam int NB    = 2;
  localparam int HOT   = 165;
  localparam int LEAVE = 150;
  localparam int V_ON  = 70;
  localparam int V_OFF = 60;
  localparam int DLY   = 4;
  localparam int DIS   = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] en_req = '0;
  logic [NB-1:0] oc_flag = '0;
  logic [7:0]    temp_code = 8'd25;
  logic [7:0]    vsup_code = 8'd0;
  logic          clr_stb = 1'b0;
  logic [NB-1:0] br_en;
  logic [NB-1:0] oc_off;
  logic          ot_act;
  logic          uv_act;
  logic [NB+1:0] flt_sticky;

  always #2.5 clk = ~clk;

  brg_fault_sup #(.NB(NB), .DLY_CYC(DLY), .DIS_CYC(DIS)) u0 (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .oc_flag(oc_flag),
    .temp_code(temp_code), .vsup_code(vsup_code), .clr_stb(clr_stb),
    .br_en(br_en), .oc_off(oc_off), .ot_act(ot_act), .uv_act(uv_act),
    .flt_sticky(flt_sticky)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model: phase 0 idle, 1 delay, 2 off; left = cycles remaining
  int            m_ph [NB];
  int            m_left [NB];
  bit            m_ot, m_uv;
  logic [NB+1:0] m_st;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit f_ot(bit cur, int t);
    if (cur) return !(t <= LEAVE);
    return t >= HOT;
  endfunction

  function automatic bit f_uv(bit cur, int v);
    if (cur) return !(v >= V_ON);
    return v < V_OFF;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_ph[i] = 0; m_left[i] = 0; end
    m_ot = 0; m_uv = 1; m_st = '0;
  endtask

  task automatic model_step();
    bit gf;
    bit n_ot, n_uv;
    logic [NB+1:0] setv;
    gf = m_ot | m_uv;
    setv = '0;
    for (int i = 0; i < NB; i++) begin
      if (gf) begin
        m_ph[i] = 0;
      end else if (m_ph[i] == 0) begin
        if (oc_flag[i]) begin m_ph[i] = 1; m_left[i] = DLY; setv[i] = 1'b1; end
      end else if (m_ph[i] == 1) begin
        if (m_left[i] == 1) begin m_ph[i] = 2; m_left[i] = DIS; end
        else m_left[i]--;
      end else begin
        if (m_left[i] == 1) begin
          if (oc_flag[i]) begin m_ph[i] = 1; m_left[i] = DLY; setv[i] = 1'b1; end
          else m_ph[i] = 0;
        end else m_left[i]--;
      end
    end
    n_ot = f_ot(m_ot, int'(temp_code));
    n_uv = f_uv(m_uv, int'(vsup_code));
    if (!m_ot && n_ot) setv[NB] = 1'b1;
    if (!m_uv && n_uv) setv[NB+1] = 1'b1;
    m_ot = n_ot; m_uv = n_uv;
    m_st = (clr_stb ? '0 : m_st) | setv;
  endtask

  task automatic compare_all();
    for (int i = 0; i < NB; i++) begin
      chk("R2", $sformatf("br_en[%0d]", i), br_en[i],
          int'(en_req[i] && m_ph[i] != 2 && !m_ot && !m_uv));
      chk("R3", $sformatf("oc_off[%0d]", i), oc_off[i], int'(m_ph[i] == 2));
    end
    chk("R6", "ot_act", ot_act, m_ot);
    chk("R7", "uv_act", uv_act, m_uv);
    chk("R9", "flt_sticky", flt_sticky, m_st);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "uv_act in reset", uv_act, 1);
    chk("R1", "ot_act in reset", ot_act, 0);
    chk("R1", "br_en in reset", br_en, 0);
    chk("R1", "sticky in reset", flt_sticky, 0);
    chk("R1", "oc_off in reset", oc_off, 0);
    rst_n = 1'b1;
    en_req = 2'b11;
    step();
    chk("R1", "uv_act after reset", uv_act, 1);
    chk("R1", "br_en after reset", br_en, 0);

    // R7: undervoltage thresholds
    vsup_code = 8'd69; step();
    chk("R7", "uv holds at 69", uv_act, 1);
    vsup_code = 8'd70; step();
    chk("R7", "uv releases at 70", uv_act, 0);
    chk("R2", "enables follow request", br_en, 2'b11);
    vsup_code = 8'd60; step();
    chk("R7", "uv stays clear at 60", uv_act, 0);
    vsup_code = 8'd59; step();
    chk("R7", "uv engages at 59", uv_act, 1);
    chk("R9", "sticky uv bit3", flt_sticky[NB+1], 1);
    vsup_code = 8'd65; step();
    chk("R7", "uv holds at 65", uv_act, 1);
    vsup_code = 8'd75; step();
    chk("R7", "uv releases at 75", uv_act, 0);
    en_req = 2'b01; step();
    chk("R2", "bridge1 follows low request", br_en, 2'b01);
    en_req = 2'b11; step();

    // R3/R4: single overcurrent pulse on bridge 0
    oc_flag = 2'b01; step();
    oc_flag = 2'b00;
    repeat (DLY - 1) step();
    chk("R3", "bridge0 on during delay", br_en[0], 1);
    step();
    chk("R3", "bridge0 off after delay", oc_off[0], 1);
    chk("R4", "bridge1 unaffected", br_en[1], 1);
    chk("R9", "sticky oc bit0", flt_sticky[0], 1);
    repeat (DIS - 1) begin
      step();
      chk("R4", "bridge1 on in window", br_en[1], 1);
    end
    chk("R3", "bridge0 still off last cycle", oc_off[0], 1);
    step();
    chk("R3", "bridge0 recovers", br_en[0], 1);

    // R5: held overcurrent on bridge 1 retries
    oc_flag = 2'b10; step();
    repeat (DLY) step();
    chk("R5", "bridge1 off first window", oc_off[1], 1);
    repeat (DIS) step();
    chk("R5", "bridge1 back on for retry delay", br_en[1], 1);
    chk("R4", "bridge0 untouched by bridge1", br_en[0], 1);
    repeat (DLY) step();
    chk("R5", "bridge1 off again", oc_off[1], 1);
    oc_flag = 2'b00;
    repeat (DIS + 2) step();
    chk("R5", "bridge1 settles on", br_en[1], 1);

    // R6/R8: thermal fault during an open window
    temp_code = 8'd164; step();
    chk("R6", "no trip at 164", ot_act, 0);
    oc_flag = 2'b01; step();
    oc_flag = 2'b00;
    repeat (DLY + 3) step();
    chk("R8", "window open before fault", oc_off[0], 1);
    temp_code = 8'd170; step();
    chk("R6", "trip at 170", ot_act, 1);
    chk("R8", "both bridges off", br_en, 2'b00);
    oc_flag = 2'b11; step();
    chk("R8", "timer cancelled", oc_off[0], 0);
    oc_flag = 2'b00;
    temp_code = 8'd151; step();
    chk("R6", "holds at 151", ot_act, 1);
    chk("R9", "all sticky bits set", flt_sticky, 4'b1111);
    temp_code = 8'd150; step();
    chk("R6", "releases at 150", ot_act, 0);
    chk("R8", "bridges on with no pending window", br_en, 2'b11);

    // R9: clear strobe and set-wins
    clr_stb = 1'b1; step();
    clr_stb = 1'b0;
    chk("R9", "sticky cleared", flt_sticky, 0);
    clr_stb = 1'b1; oc_flag = 2'b10; step();
    clr_stb = 1'b0; oc_flag = 2'b00;
    chk("R9", "set wins over clear", flt_sticky, 4'b0010);
    repeat (DLY + DIS + 2) step();

    // random phase near the thresholds
    for (int k = 0; k < 4000; k++) begin
      en_req    = NB'($urandom_range(0, 3));
      oc_flag   = '0;
      for (int i = 0; i < NB; i++) oc_flag[i] = ($urandom_range(0, 99) < 4);
      temp_code = 8'($urandom_range(140, 175));
      vsup_code = ($urandom_range(0, 9) < 8) ? 8'($urandom_range(66, 90))
                                             : 8'($urandom_range(55, 72));
      clr_stb   = ($urandom_range(0, 49) == 0);
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule